// File: doc/BRIEF.md
# Processor Powerdown Sequencer

This block takes a processor from normal running into powerdown and back. When a powerdown request arrives, the block first makes sure the block-DMA engine is idle. It does this in one of two ways. In the first, it waits for the engine's remaining word count to fall to zero. In the second, it writes a one into that count to cut the transfer short, then waits for zero. Next it switches off the analog interface. It allows that interface a fixed number of settle cycles, and only after them raises the core idle state and the powerdown acknowledge.

While powered down, the block parks the external interface:

- Memory-select and read/write strobes are driven high.
- Address and data outputs are released to high impedance.
- Incoming data is ignored.
- The clock output and the acknowledge are held high.
- The general-purpose flags keep their last value.

External interrupts are still latched in this state, but they are not offered for service. A bus request that arrives is not answered until the processor wakes. Dropping the request, or a reset, brings the processor back to running in one cycle.

Top module: `pwrdn_seq_ctrl`

## Requirements
- R1: The analog shutdown (and therefore powerdown) never starts unless `dma_count` read zero in the cycle before. In wait mode (`abort_mode`=0 at the request) the sequencer keeps polling until the count reads zero.
- R2: `abort_mode` is sampled in the cycle the request is accepted. When it is 1, `dma_wr_en` pulses for exactly one cycle with `dma_wr_val`=1. If the count was nonzero during that pulse, `abort_flag` is set. The flag is cleared when the next request is accepted.
- R3: `ana_off` stays high for at least ANA_CYC (default 3) consecutive cycles before `core_idle` and `pd_ack` rise, and the two rise together.
- R4: In powerdown, every strobe bit of `strb_o` is 1. `strb_oe` is 1 unless the bus is granted (`bg_n`=0), in which case it is 0.
- R5: In powerdown, `addr_oe` and `dout_oe` are 0. `core_din` holds the pad value from the last cycle before powerdown and ignores `pad_din`.
- R6: In powerdown, `clkout` and `pd_ack` are 1. Outside powerdown, `clkout` follows `core_clk` and `pd_ack` is 0.
- R7: Each `irq_in` bit sets a pending bit in any state, and the matching `irq_ack` bit clears it. `irq_svc` shows the pending bits outside powerdown and is all zero during powerdown.
- R8: A grant (`bg_n`=0) follows a high `bus_req` one cycle later outside powerdown, and ends one cycle after `bus_req` falls. During powerdown no new grant is given, and an existing grant is kept while `bus_req` stays high.
- R9: During powerdown, `flag_o` holds the `core_flag` value from the last cycle before powerdown.
- R10: With `pd_req` low in any sequencing state, the next cycle is running: `pd_ack`, `core_idle` and `ana_off` are 0 and the outputs are released.
- R11: After synchronous reset the block is running with no grant, no pending interrupts and `abort_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | Powerdown request; low means wake |
| abort_mode | input | 1 | 1 = abort DMA, 0 = wait for DMA |
| dma_count | input | CW | Remaining block-DMA word count |
| dma_wr_en | output | 1 | Write strobe to the DMA word count |
| dma_wr_val | output | CW | Value written to the DMA word count (1) |
| abort_flag | output | 1 | Last abort cut a transfer short |
| ana_off | output | 1 | Analog interface disable |
| core_idle | output | 1 | Core idle/powerdown state |
| pd_ack | output | 1 | Powerdown acknowledge |
| core_clk | input | 1 | Clock output source from the core |
| clkout | output | 1 | Clock output pin value |
| core_strb | input | NS | Core memory-select and read/write strobes (active low) |
| strb_o | output | NS | Strobe pin values |
| strb_oe | output | 1 | Strobe output enable |
| core_addr | input | AW | Core address |
| addr_o | output | AW | Address pin values |
| addr_oe | output | 1 | Address output enable |
| core_dout | input | DW | Core write data |
| core_dout_oe | input | 1 | Core wants to drive data |
| dout_o | output | DW | Data pin output values |
| dout_oe | output | 1 | Data output enable |
| pad_din | input | DW | Data pin input values |
| core_din | output | DW | Data delivered to the core |
| irq_in | input | NI | External interrupt inputs |
| irq_ack | input | NI | Interrupt service acknowledge |
| irq_svc | output | NI | Interrupts offered for service |
| bus_req | input | 1 | External bus request |
| bg_n | output | 1 | Bus grant, active low |
| core_flag | input | NF | Core flag outputs |
| flag_o | output | NF | Flag pin values |

## Verification
The hardest case to reach is a grant that is already in place when the parked state begins. The request must arrive, and the grant must be issued, before the sequencer leaves running, and `bus_req` must then be held through drain and settle. The stimulus raises `bus_req` first, then the powerdown request, and drops `bus_req` in the middle of powerdown so that the strobes change from high impedance to driven high. An abort that lands on a count that is already zero, a wake in the middle of the settle period, and a reset during powerdown are driven as separate episodes.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_DRAIN = 3'd1,
        ST_ABORT = 3'd2,
        ST_ANA   = 3'd3,
        ST_DOWN  = 3'd4
    } pdc_state_e;

    typedef struct packed {
        logic parked;
        logic analog_off;
    } pdc_mode_t;

    function automatic pdc_mode_t pdc_decode(pdc_state_e s);
        pdc_mode_t m;
        m.parked     = (s == ST_DOWN);
        m.analog_off = (s == ST_ANA) || (s == ST_DOWN);
        return m;
    endfunction

endpackage

// File: rtl/pdc_seq.sv
module pdc_seq
    import pdc_pkg::*;
#(
    parameter int CW      = 14,
    parameter int ANA_CYC = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pd_req,
    input  logic          abort_mode,
    input  logic [CW-1:0] dma_count,
    output pdc_state_e    state_o,
    output logic          dma_wr_en,
    output logic          abort_flag
);
    localparam int SW = $clog2(ANA_CYC + 1);
    localparam logic [SW-1:0] SLAST = SW'(ANA_CYC - 1);

    pdc_state_e    state_q, state_d;
    logic [SW-1:0] settle_q;
    logic          dma_idle;

    assign dma_idle = (dma_count == '0);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:   if (pd_req) state_d = abort_mode ? ST_ABORT : ST_DRAIN;
            ST_ABORT: state_d = pd_req ? ST_DRAIN : ST_RUN;
            ST_DRAIN: if (!pd_req) state_d = ST_RUN;
                      else if (dma_idle) state_d = ST_ANA;
            ST_ANA:   if (!pd_req) state_d = ST_RUN;
                      else if (settle_q == SLAST) state_d = ST_DOWN;
            ST_DOWN:  if (!pd_req) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RUN;
            settle_q   <= '0;
            abort_flag <= 1'b0;
        end else begin
            state_q  <= state_d;
            settle_q <= (state_q == ST_ANA && state_d == ST_ANA) ? settle_q + 1'b1 : '0;
            if (state_q == ST_RUN && pd_req)
                abort_flag <= 1'b0;
            else if (state_q == ST_ABORT && !dma_idle)
                abort_flag <= 1'b1;
        end
    end

    assign state_o   = state_q;
    assign dma_wr_en = (state_q == ST_ABORT);

endmodule

// File: rtl/pdc_irq_latch.sv
module pdc_irq_latch #(
    parameter int NI = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          parked,
    input  logic [NI-1:0] irq_in,
    input  logic [NI-1:0] irq_ack,
    output logic [NI-1:0] irq_svc
);
    logic [NI-1:0] pend_q;

    for (genvar i = 0; i < NI; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) pend_q[i] <= 1'b0;
            else     pend_q[i] <= (pend_q[i] & ~irq_ack[i]) | irq_in[i];
        end
        assign irq_svc[i] = pend_q[i] & ~parked;
    end

endmodule

// File: rtl/pdc_park.sv
module pdc_park #(
    parameter int NS = 6,
    parameter int AW = 14,
    parameter int DW = 24,
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          parked,
    input  logic          bus_req,
    output logic          bg_n,
    input  logic          core_clk,
    output logic          clkout,
    input  logic [NS-1:0] core_strb,
    output logic [NS-1:0] strb_o,
    output logic          strb_oe,
    input  logic [AW-1:0] core_addr,
    output logic [AW-1:0] addr_o,
    output logic          addr_oe,
    input  logic [DW-1:0] core_dout,
    input  logic          core_dout_oe,
    output logic [DW-1:0] dout_o,
    output logic          dout_oe,
    input  logic [DW-1:0] pad_din,
    output logic [DW-1:0] core_din,
    input  logic [NF-1:0] core_flag,
    output logic [NF-1:0] flag_o
);
    logic          gnt_q;
    logic [DW-1:0] din_hold_q;
    logic [NF-1:0] flag_hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q       <= 1'b0;
            din_hold_q  <= '0;
            flag_hold_q <= '0;
        end else begin
            gnt_q <= bus_req & (gnt_q | ~parked);
            if (!parked) begin
                din_hold_q  <= pad_din;
                flag_hold_q <= core_flag;
            end
        end
    end

    assign bg_n     = ~gnt_q;
    assign clkout   = parked ? 1'b1 : core_clk;
    assign strb_o   = parked ? '1 : core_strb;
    assign strb_oe  = ~gnt_q;
    assign addr_o   = core_addr;
    assign addr_oe  = ~parked & ~gnt_q;
    assign dout_o   = core_dout;
    assign dout_oe  = core_dout_oe & ~parked & ~gnt_q;
    assign core_din = parked ? din_hold_q : pad_din;
    assign flag_o   = parked ? flag_hold_q : core_flag;

endmodule

// File: rtl/pwrdn_seq_ctrl.sv
module pwrdn_seq_ctrl
    import pdc_pkg::*;
#(
    parameter int CW      = 14,
    parameter int AW      = 14,
    parameter int DW      = 24,
    parameter int NS      = 6,
    parameter int NI      = 4,
    parameter int NF      = 3,
    parameter int ANA_CYC = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pd_req,
    input  logic          abort_mode,
    input  logic [CW-1:0] dma_count,
    output logic          dma_wr_en,
    output logic [CW-1:0] dma_wr_val,
    output logic          abort_flag,
    output logic          ana_off,
    output logic          core_idle,
    output logic          pd_ack,
    input  logic          core_clk,
    output logic          clkout,
    input  logic [NS-1:0] core_strb,
    output logic [NS-1:0] strb_o,
    output logic          strb_oe,
    input  logic [AW-1:0] core_addr,
    output logic [AW-1:0] addr_o,
    output logic          addr_oe,
    input  logic [DW-1:0] core_dout,
    input  logic          core_dout_oe,
    output logic [DW-1:0] dout_o,
    output logic          dout_oe,
    input  logic [DW-1:0] pad_din,
    output logic [DW-1:0] core_din,
    input  logic [NI-1:0] irq_in,
    input  logic [NI-1:0] irq_ack,
    output logic [NI-1:0] irq_svc,
    input  logic          bus_req,
    output logic          bg_n,
    input  logic [NF-1:0] core_flag,
    output logic [NF-1:0] flag_o
);
    pdc_state_e state;
    pdc_mode_t  mode;

    pdc_seq #(.CW(CW), .ANA_CYC(ANA_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pd_req     (pd_req),
        .abort_mode (abort_mode),
        .dma_count  (dma_count),
        .state_o    (state),
        .dma_wr_en  (dma_wr_en),
        .abort_flag (abort_flag)
    );

    assign mode       = pdc_decode(state);
    assign dma_wr_val = CW'(1);
    assign ana_off    = mode.analog_off;
    assign core_idle  = mode.parked;
    assign pd_ack     = mode.parked;

    pdc_irq_latch #(.NI(NI)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .parked  (mode.parked),
        .irq_in  (irq_in),
        .irq_ack (irq_ack),
        .irq_svc (irq_svc)
    );

    pdc_park #(.NS(NS), .AW(AW), .DW(DW), .NF(NF)) u_park (
        .clk          (clk),
        .rst          (rst),
        .parked       (mode.parked),
        .bus_req      (bus_req),
        .bg_n         (bg_n),
        .core_clk     (core_clk),
        .clkout       (clkout),
        .core_strb    (core_strb),
        .strb_o       (strb_o),
        .strb_oe      (strb_oe),
        .core_addr    (core_addr),
        .addr_o       (addr_o),
        .addr_oe      (addr_oe),
        .core_dout    (core_dout),
        .core_dout_oe (core_dout_oe),
        .dout_o       (dout_o),
        .dout_oe      (dout_oe),
        .pad_din      (pad_din),
        .core_din     (core_din),
        .core_flag    (core_flag),
        .flag_o       (flag_o)
    );

endmodule

// File: rtl/pdc_chk.sv
module pdc_chk #(
    parameter int CW      = 14,
    parameter int NS      = 6,
    parameter int NI      = 4,
    parameter int NF      = 3,
    parameter int ANA_CYC = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          pd_req,
    input logic [CW-1:0] dma_count,
    input logic          dma_wr_en,
    input logic          ana_off,
    input logic          core_idle,
    input logic          pd_ack,
    input logic          clkout,
    input logic [NS-1:0] strb_o,
    input logic          strb_oe,
    input logic          addr_oe,
    input logic          dout_oe,
    input logic [NI-1:0] irq_svc,
    input logic          bg_n,
    input logic [NF-1:0] flag_o
);
    int unsigned off_run;

    always_ff @(posedge clk) begin
        if (rst || !ana_off) off_run <= 0;
        else if (off_run < ANA_CYC) off_run <= off_run + 1;
    end

    a_r1_zero_before_shutdown: assert property (@(posedge clk) disable iff (rst)
        $rose(ana_off) |-> ($past(dma_count) == '0));

    a_r2_single_abort_write: assert property (@(posedge clk) disable iff (rst)
        dma_wr_en |=> (!dma_wr_en && !ana_off));

    a_r3_settle_before_idle: assert property (@(posedge clk) disable iff (rst)
        core_idle |-> (off_run >= ANA_CYC && pd_ack));

    a_r4_strobes_parked: assert property (@(posedge clk) disable iff (rst)
        pd_ack |-> ((&strb_o) && (strb_oe == bg_n)));

    a_r5_bus_released: assert property (@(posedge clk) disable iff (rst)
        pd_ack |-> (!addr_oe && !dout_oe));

    a_r6_clock_high: assert property (@(posedge clk) disable iff (rst)
        pd_ack |-> clkout);

    a_r7_no_service: assert property (@(posedge clk) disable iff (rst)
        pd_ack |-> (irq_svc == '0));

    a_r8_no_new_grant: assert property (@(posedge clk) disable iff (rst)
        (pd_ack && $past(pd_ack) && $past(bg_n)) |-> bg_n);

    a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (pd_ack && $past(pd_ack)) |-> $stable(flag_o));

    a_r10_wake: assert property (@(posedge clk) disable iff (rst)
        (!pd_req && pd_ack) |=> (!pd_ack && !ana_off));

endmodule

bind pwrdn_seq_ctrl pdc_chk #(
    .CW(CW), .NS(NS), .NI(NI), .NF(NF), .ANA_CYC(ANA_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pd_req    (pd_req),
    .dma_count (dma_count),
    .dma_wr_en (dma_wr_en),
    .ana_off   (ana_off),
    .core_idle (core_idle),
    .pd_ack    (pd_ack),
    .clkout    (clkout),
    .strb_o    (strb_o),
    .strb_oe   (strb_oe),
    .addr_oe   (addr_oe),
    .dout_oe   (dout_oe),
    .irq_svc   (irq_svc),
    .bg_n      (bg_n),
    .flag_o    (flag_o)
);

// File: tb/pwrdn_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pwrdn_seq_ctrl_bench;
    localparam int CW = 14, AW = 14, DW = 24, NS = 6, NI = 4, NF = 3, ANA = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1, pd_req = 1'b0, abort_mode = 1'b0;
    logic [CW-1:0] dcnt = '0;
    logic          dma_wr_en, abort_flag, ana_off, core_idle, pd_ack, clkout;
    logic [CW-1:0] dma_wr_val;
    logic          core_clk = 1'b0;
    logic [NS-1:0] core_strb = '1, strb_o;
    logic          strb_oe, addr_oe, dout_oe, bg_n;
    logic [AW-1:0] core_addr = '0, addr_o;
    logic [DW-1:0] core_dout = '0, dout_o, pad_din = '0, core_din;
    logic          core_dout_oe = 1'b0, bus_req = 1'b0;
    logic [NI-1:0] irq_in = '0, irq_ack = '0, irq_svc;
    logic [NF-1:0] core_flag = '0, flag_o;

    pwrdn_seq_ctrl #(.CW(CW), .AW(AW), .DW(DW), .NS(NS), .NI(NI), .NF(NF), .ANA_CYC(ANA))
    u_pwrdn_seq_ctrl (
        .clk(clk), .rst(rst), .pd_req(pd_req), .abort_mode(abort_mode),
        .dma_count(dcnt), .dma_wr_en(dma_wr_en), .dma_wr_val(dma_wr_val),
        .abort_flag(abort_flag), .ana_off(ana_off), .core_idle(core_idle),
        .pd_ack(pd_ack), .core_clk(core_clk), .clkout(clkout),
        .core_strb(core_strb), .strb_o(strb_o), .strb_oe(strb_oe),
        .core_addr(core_addr), .addr_o(addr_o), .addr_oe(addr_oe),
        .core_dout(core_dout), .core_dout_oe(core_dout_oe), .dout_o(dout_o),
        .dout_oe(dout_oe), .pad_din(pad_din), .core_din(core_din),
        .irq_in(irq_in), .irq_ack(irq_ack), .irq_svc(irq_svc),
        .bus_req(bus_req), .bg_n(bg_n), .core_flag(core_flag), .flag_o(flag_o)
    );

    int checks = 0, failures = 0;
    bit compare_on = 0;

    // reference model state: 0 run, 1 drain, 2 abort, 3 settle, 4 down
    int            m_st = 0, m_settle = 0;
    bit            m_flag = 0, m_gnt = 0;
    logic [NI-1:0] m_pend = '0;
    logic [DW-1:0] m_din = '0;
    logic [NF-1:0] m_fl = '0;

    task automatic chk(string rq, string nm, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", rq, nm, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit dn;
        dn = (m_st == 4);
        chk("R1", "ana_off", 64'(ana_off), 64'(m_st == 3 || dn));
        chk("R2", "dma_wr_en", 64'(dma_wr_en), 64'(m_st == 2));
        chk("R2", "dma_wr_val", 64'(dma_wr_val), 64'd1);
        chk("R2", "abort_flag", 64'(abort_flag), 64'(m_flag));
        chk("R3", "core_idle", 64'(core_idle), 64'(dn));
        chk("R6", "pd_ack", 64'(pd_ack), 64'(dn));
        chk("R6", "clkout", 64'(clkout), 64'(dn ? 1'b1 : core_clk));
        chk("R4", "strb_o", 64'(strb_o), 64'(dn ? {NS{1'b1}} : core_strb));
        chk("R4", "strb_oe", 64'(strb_oe), 64'(!m_gnt));
        chk("R8", "bg_n", 64'(bg_n), 64'(!m_gnt));
        chk("R5", "addr_oe", 64'(addr_oe), 64'(!dn && !m_gnt));
        chk("R5", "dout_oe", 64'(dout_oe), 64'(core_dout_oe && !dn && !m_gnt));
        chk("R5", "addr_o", 64'(addr_o), 64'(core_addr));
        chk("R5", "dout_o", 64'(dout_o), 64'(core_dout));
        chk("R5", "core_din", 64'(core_din), 64'(dn ? m_din : pad_din));
        chk("R7", "irq_svc", 64'(irq_svc), 64'(dn ? '0 : m_pend));
        chk("R9", "flag_o", 64'(flag_o), 64'(dn ? m_fl : core_flag));
    endtask

    task automatic model_edge(bit wr);
        int st;
        st = m_st;
        if (rst) begin
            m_st = 0; m_settle = 0; m_flag = 0; m_gnt = 0;
            m_pend = '0; m_din = '0; m_fl = '0;
        end else begin
            m_pend = (m_pend & ~irq_ack) | irq_in;
            m_gnt  = bus_req && (m_gnt || st != 4);
            if (st != 4) begin m_din = pad_din; m_fl = core_flag; end
            m_settle = 0;
            case (st)
                0: if (pd_req) begin m_flag = 0; m_st = abort_mode ? 2 : 1; end
                2: begin if (dcnt != 0) m_flag = 1; m_st = pd_req ? 1 : 0; end
                1: if (!pd_req) m_st = 0; else if (dcnt == 0) m_st = 3;
                3: if (!pd_req) m_st = 0;
                   else if (m_settle_prev == ANA - 1) m_st = 4;
                   else begin m_st = 3; m_settle = m_settle_prev + 1; end
                default: if (!pd_req) m_st = 0;
            endcase
        end
        if (wr) dcnt = CW'(1);
        else if (dcnt != 0) dcnt = dcnt - 1'b1;
    endtask

    int m_settle_prev = 0;

    task automatic step();
        bit wr;
        core_clk  = ~core_clk;
        core_strb = NS'($urandom);
        core_addr = AW'($urandom);
        core_dout = DW'($urandom);
        core_dout_oe = 1'($urandom);
        pad_din   = DW'($urandom);
        core_flag = NF'($urandom);
        irq_in    = (($urandom % 5) == 0) ? NI'($urandom) : '0;
        irq_ack   = (($urandom % 3) == 0) ? NI'($urandom) : '0;
        #1;
        if (compare_on) compare();
        wr = dma_wr_en;
        m_settle_prev = m_settle;
        @(posedge clk);
        #1;
        model_edge(wr);
        compare_on = 1;
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R11: reset state
        rst = 1'b1; run(2);
        rst = 1'b0; run(1);
        chk("R11", "bg_n after reset", 64'(bg_n), 64'd1);
        chk("R11", "abort_flag after reset", 64'(abort_flag), 64'd0);
        // R8: plain grant while running
        bus_req = 1'b1; run(4); bus_req = 1'b0; run(3);
        // R1: wait mode, transfer in progress
        dcnt = CW'(20); abort_mode = 1'b0; pd_req = 1'b1; run(8);
        chk("R1", "not parked while count nonzero", 64'(pd_ack), 64'd0);
        run(30);
        chk("R6", "parked after drain", 64'(pd_ack), 64'd1);
        // R8: request during powerdown gets no answer
        bus_req = 1'b1; run(6);
        chk("R8", "no grant while parked", 64'(bg_n), 64'd1);
        // R10: wake
        pd_req = 1'b0; run(1);
        chk("R10", "awake next cycle", 64'(pd_ack), 64'd0);
        run(3);
        chk("R8", "grant after wake", 64'(bg_n), 64'd0);
        bus_req = 1'b0; run(3);
        // R2: abort mode with an active transfer
        dcnt = CW'(50); abort_mode = 1'b1; pd_req = 1'b1; run(1);
        abort_mode = 1'b0; run(12);
        chk("R2", "abort flagged", 64'(abort_flag), 64'd1);
        chk("R3", "parked after abort", 64'(pd_ack), 64'd1);
        pd_req = 1'b0; run(3);
        // R2: abort with idle DMA leaves flag clear
        abort_mode = 1'b1; pd_req = 1'b1; run(10);
        chk("R2", "flag clear on idle abort", 64'(abort_flag), 64'd0);
        pd_req = 1'b0; abort_mode = 1'b0; run(3);
        // R4: parked with bus already granted, then released mid-powerdown
        bus_req = 1'b1; run(3);
        pd_req = 1'b1; run(10);
        chk("R4", "strobes released while granted", 64'(strb_oe), 64'd0);
        bus_req = 1'b0; run(3);
        chk("R4", "strobes driven after release", 64'(strb_oe), 64'd1);
        pd_req = 1'b0; run(3);
        // R10: wake during settle
        pd_req = 1'b1; run(3);
        pd_req = 1'b0; run(1);
        chk("R10", "analog back on", 64'(ana_off), 64'd0);
        run(2);
        // R11: reset while parked
        pd_req = 1'b1; run(10);
        rst = 1'b1; run(1);
        chk("R11", "reset leaves powerdown", 64'(pd_ack), 64'd0);
        rst = 1'b0; pd_req = 1'b0; run(5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule